// File: doc/BRIEF.md
# Configurable GPIO Port

This block is an eight-bit general-purpose I/O port built from identical bit slices. Software sets each bit through three per-pin registers: a direction bit, an option bit and an output data bit. The direction and option bits together pick one of four pin modes. These are floating input, input with pull-up and interrupt capability, open-drain output and push-pull output. The block does not model an analog pad. Instead it drives a pad model through a drive value, a drive enable and a pull-up enable for each bit, and it samples the resolved pad level back on `pad_in`.

An on-chip peripheral can take over any bit through its alternate-function enable. The bit then drives the peripheral's output value in push-pull fashion, whatever the direction register holds. Each bit that is an input with the option bit set can raise an interrupt request. One sensitivity setting is shared by all eight bits and offers four choices: low level (not latched), falling edge, rising edge, or both edges. The three edge modes are latched.

The pad level passes through a two-stage synchronizer before edge detection and before it is read back through the data register address. A latched request stays set until software writes a one to that bit at the request address.

Top module: `gpio_port`

## Requirements
- R1: After reset the direction, option and data registers read 0, the sensitivity reads 00, no bit drives its pad or enables its pull-up, and `irq` is 0.
- R2: With direction=0 and option=0 (floating input) a bit neither drives its pad nor enables its pull-up.
- R3: With direction=1 and option=0 (open-drain) a bit drives 0 when its data bit is 0 and releases the pad (drive enable 0) when its data bit is 1. It never drives a high level.
- R4: With direction=1 and option=1 (push-pull) a bit always drives, and the driven value equals its data bit.
- R5: With direction=0 and option=1 (input with pull-up) a bit enables its pull-up and does not drive.
- R6: When `alt_en` of a bit is 1, the bit drives `alt_out` with drive enable 1 and pull-up disabled, regardless of its registers, and it cannot raise an interrupt.
- R7: Register map, with address on `bus_addr`: 0 = data (write: output data, read: pad level), 1 = direction, 2 = option, 3 = request bits (write 1 to clear), 4 = sensitivity in bits [1:0]. Other addresses read 0. A pad change becomes visible in the data read after the second rising clock edge, not after the first.
- R8: A bit may raise an interrupt only when direction=0, option=1 and `alt_en`=0. Pad activity on any other bit leaves its request at 0.
- R9: Sensitivity 01 latches a request on a falling pad edge, 10 on a rising edge, and 11 on either edge. A latched request stays set until a write to address 3 with a 1 in that bit position. Zero bits in that write leave requests unchanged.
- R10: Sensitivity 00 makes the request of an enabled bit follow the low pad level without latching. The request drops as soon as the synchronized pad is high.
- R11: `irq_req` shows the per-bit requests, the same value is read at address 3, and `irq` is their OR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| pad_in | input | 8 | Resolved pad level, asynchronous |
| pad_drive_val | output | 8 | Value to drive on each pad |
| pad_drive_en | output | 8 | Drive enable for each pad |
| pad_pullup_en | output | 8 | Pull-up enable for each pad |
| alt_en | input | 8 | Peripheral alternate-function enable per bit |
| alt_out | input | 8 | Peripheral output value per bit |
| irq_req | output | 8 | Per-bit interrupt request |
| irq | output | 1 | OR of all requests |

## Verification
The latch-hold assertion assumes that direction, option, alternate enable and sensitivity stay unchanged between the two cycles it compares. It checks only those cycles. The bench applies every configuration change as a separate register write and waits several cycles before any edge it counts on. The bench's pad model never lets the external driver fight the block's own drive, because the block's drive always takes priority. Random configurations keep the alternate enable sparse, so that all four register modes appear often.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_DATA = 3'd0,
        REG_DIR  = 3'd1,
        REG_OPT  = 3'd2,
        REG_REQ  = 3'd3,
        REG_SENS = 3'd4
    } reg_sel_e;

    typedef enum logic [1:0] {
        SENS_LOW  = 2'b00,
        SENS_FALL = 2'b01,
        SENS_RISE = 2'b10,
        SENS_BOTH = 2'b11
    } sens_e;

    typedef struct packed {
        logic dir;
        logic opt;
        logic data;
    } bit_cfg_t;

    typedef struct packed {
        logic drv_en;
        logic drv_val;
        logic pull_en;
    } pad_ctl_t;

    // Output stage of one bit: alternate function wins, then direction/option.
    function automatic pad_ctl_t pad_decode(bit_cfg_t c, logic alt, logic alt_val);
        pad_ctl_t p;
        p.pull_en = ~alt & ~c.dir & c.opt;
        if (alt) begin
            p.drv_en  = 1'b1;
            p.drv_val = alt_val;
        end else if (c.dir && c.opt) begin
            p.drv_en  = 1'b1;
            p.drv_val = c.data;
        end else if (c.dir) begin
            p.drv_en  = ~c.data;
            p.drv_val = 1'b0;
        end else begin
            p.drv_en  = 1'b0;
            p.drv_val = 1'b0;
        end
        return p;
    endfunction

    function automatic logic sens_latched(sens_e s);
        return s != SENS_LOW;
    endfunction

    function automatic logic edge_hit(sens_e s, logic prev, logic cur);
        case (s)
            SENS_FALL: return prev & ~cur;
            SENS_RISE: return ~prev & cur;
            SENS_BOTH: return prev ^ cur;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [WIDTH-1:0]     bus_wdata,
    output logic [WIDTH-1:0]     dir_q,
    output logic [WIDTH-1:0]     opt_q,
    output logic [WIDTH-1:0]     data_q,
    output sens_e                sens_q,
    output logic [WIDTH-1:0]     clr_mask
);

    reg_sel_e sel;
    assign sel = reg_sel_e'(bus_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q  <= '0;
            opt_q  <= '0;
            data_q <= '0;
            sens_q <= SENS_LOW;
        end else if (bus_we) begin
            case (sel)
                REG_DATA: data_q <= bus_wdata;
                REG_DIR:  dir_q  <= bus_wdata;
                REG_OPT:  opt_q  <= bus_wdata;
                REG_SENS: sens_q <= sens_e'(bus_wdata[1:0]);
                default:  ;
            endcase
        end
    end

    assign clr_mask = (bus_we && sel == REG_REQ) ? bus_wdata : '0;

endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] opt_q,
    input  logic [WIDTH-1:0] data_q,
    input  logic [WIDTH-1:0] alt_en,
    input  logic [WIDTH-1:0] alt_out,
    output logic [WIDTH-1:0] drv_val,
    output logic [WIDTH-1:0] drv_en,
    output logic [WIDTH-1:0] pull_en
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        bit_cfg_t cfg;
        pad_ctl_t ctl;
        assign cfg = '{dir: dir_q[i], opt: opt_q[i], data: data_q[i]};
        assign ctl = pad_decode(cfg, alt_en[i], alt_out[i]);
        assign drv_val[i] = ctl.drv_val;
        assign drv_en[i]  = ctl.drv_en;
        assign pull_en[i] = ctl.pull_en;
    end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] lvl_prev
);

    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= pad_in;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[s] <= '0;
            else     stg[s] <= stg[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) lvl_prev <= '0;
        else     lvl_prev <= stg[STAGES-1];
    end

    assign lvl = stg[STAGES-1];

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] lvl,
    input  logic [WIDTH-1:0] lvl_prev,
    input  logic [WIDTH-1:0] irq_en,
    input  sens_e            sens,
    input  logic [WIDTH-1:0] clr_mask,
    output logic [WIDTH-1:0] req
);

    logic [WIDTH-1:0] pend_q;
    logic [WIDTH-1:0] hit;
    logic             latched;

    assign latched = sens_latched(sens);

    for (genvar i = 0; i < WIDTH; i++) begin : g_hit
        assign hit[i] = irq_en[i] & latched & edge_hit(sens, lvl_prev[i], lvl[i]);
    end

    // A new edge in the clearing cycle wins over the clear.
    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= (pend_q & ~clr_mask) | hit;
    end

    assign req = irq_en & (latched ? pend_q : ~lvl);

endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pad_in,
    output logic [WIDTH-1:0]  pad_drive_val,
    output logic [WIDTH-1:0]  pad_drive_en,
    output logic [WIDTH-1:0]  pad_pullup_en,
    input  logic [WIDTH-1:0]  alt_en,
    input  logic [WIDTH-1:0]  alt_out,
    output logic [WIDTH-1:0]  irq_req,
    output logic              irq
);

    logic [WIDTH-1:0] dir_q, opt_q, data_q, clr_mask;
    logic [WIDTH-1:0] lvl, lvl_prev, irq_en;
    sens_e            sens_q;

    gpio_cfg_regs #(.WIDTH(WIDTH)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .dir_q     (dir_q),
        .opt_q     (opt_q),
        .data_q    (data_q),
        .sens_q    (sens_q),
        .clr_mask  (clr_mask)
    );

    gpio_pad_drive #(.WIDTH(WIDTH)) u_drive (
        .dir_q   (dir_q),
        .opt_q   (opt_q),
        .data_q  (data_q),
        .alt_en  (alt_en),
        .alt_out (alt_out),
        .drv_val (pad_drive_val),
        .drv_en  (pad_drive_en),
        .pull_en (pad_pullup_en)
    );

    gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .pad_in   (pad_in),
        .lvl      (lvl),
        .lvl_prev (lvl_prev)
    );

    assign irq_en = ~dir_q & opt_q & ~alt_en;

    gpio_irq_detect #(.WIDTH(WIDTH)) u_irq (
        .clk      (clk),
        .rst      (rst),
        .lvl      (lvl),
        .lvl_prev (lvl_prev),
        .irq_en   (irq_en),
        .sens     (sens_q),
        .clr_mask (clr_mask),
        .req      (irq_req)
    );

    assign irq = |irq_req;

    always_comb begin
        bus_rdata = '0;
        case (reg_sel_e'(bus_addr))
            REG_DATA: bus_rdata = lvl;
            REG_DIR:  bus_rdata = dir_q;
            REG_OPT:  bus_rdata = opt_q;
            REG_REQ:  bus_rdata = irq_req;
            REG_SENS: bus_rdata[1:0] = sens_q;
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_we,
    input logic [2:0]       bus_addr,
    input logic [WIDTH-1:0] bus_wdata,
    input logic [WIDTH-1:0] pad_drive_val,
    input logic [WIDTH-1:0] pad_drive_en,
    input logic [WIDTH-1:0] pad_pullup_en,
    input logic [WIDTH-1:0] alt_en,
    input logic [WIDTH-1:0] alt_out,
    input logic [WIDTH-1:0] irq_req,
    input logic             irq,
    input logic [WIDTH-1:0] dir_q,
    input logic [WIDTH-1:0] opt_q,
    input logic [1:0]       sens_q
);

    logic [WIDTH-1:0] clr_seen;
    assign clr_seen = (bus_we && bus_addr == 3'd3) ? bus_wdata : '0;

    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pad_drive_en == '0 && pad_pullup_en == '0 && !irq));

    a_r3_open_drain_no_high: assert property (@(posedge clk) disable iff (rst)
        ((dir_q & ~opt_q & ~alt_en & pad_drive_en & pad_drive_val) == '0));

    a_r6_alt_drives_peripheral: assert property (@(posedge clk) disable iff (rst)
        (((alt_en & ~pad_drive_en) == '0) && (((pad_drive_val ^ alt_out) & alt_en) == '0)));

    a_r8_request_only_on_pulled_input: assert property (@(posedge clk) disable iff (rst)
        ((irq_req & ~pad_pullup_en) == '0));

    a_r9_latched_request_holds: assert property (@(posedge clk) disable iff (rst)
        (sens_q != 2'b00 && $stable(sens_q) && $stable(dir_q) && $stable(opt_q) && $stable(alt_en))
        |-> (($past(irq_req) & ~$past(clr_seen) & ~irq_req) == '0));

endmodule

bind gpio_port gpio_port_chk #(.WIDTH(WIDTH)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .bus_we        (bus_we),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .pad_drive_val (pad_drive_val),
    .pad_drive_en  (pad_drive_en),
    .pad_pullup_en (pad_pullup_en),
    .alt_en        (alt_en),
    .alt_out       (alt_out),
    .irq_req       (irq_req),
    .irq           (irq),
    .dir_q         (dir_q),
    .opt_q         (opt_q),
    .sens_q        (sens_q)
);

// File: tb/gpio_port_tb.sv
`timescale 1ns/1ps
module gpio_port_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_we = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata, pad_in, pad_drive_val, pad_drive_en, pad_pullup_en, irq_req;
    logic [7:0] alt_en = '0, alt_out = '0;
    logic       irq;

    // external environment of the pads
    logic [7:0] ext_en = '0, ext_val = '0, float_lvl = '0;
    // bench copy of the configuration
    logic [7:0] m_dir = '0, m_opt = '0, m_data = '0;

    int checks = 0, fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    for (genvar i = 0; i < 8; i++) begin : g_pad
        assign pad_in[i] = pad_drive_en[i] ? pad_drive_val[i] :
                           ext_en[i]       ? ext_val[i]       :
                           pad_pullup_en[i] ? 1'b1 : float_lvl[i];
    end

    gpio_port u_dut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_drive_val(pad_drive_val), .pad_drive_en(pad_drive_en),
        .pad_pullup_en(pad_pullup_en), .alt_en(alt_en), .alt_out(alt_out),
        .irq_req(irq_req), .irq(irq)
    );

    function automatic logic [7:0] exp_en();
        return alt_en | (m_dir & (m_opt | ~m_data));
    endfunction
    function automatic logic [7:0] exp_val();
        return (alt_en & alt_out) | (~alt_en & m_dir & m_opt & m_data);
    endfunction
    function automatic logic [7:0] exp_pull();
        return ~alt_en & ~m_dir & m_opt;
    endfunction
    function automatic logic [7:0] exp_pad();
        logic [7:0] e = exp_en();
        return (e & exp_val()) | (~e & ext_en & ext_val) |
               (~e & ~ext_en & (exp_pull() | float_lvl));
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
        case (a)
            3'd0: m_data = d;
            3'd1: m_dir = d;
            3'd2: m_opt = d;
            default: ;
        endcase
    endtask

    task automatic rd(logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        #(8ns * 100000);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] r;
        void'($urandom(32'd2417));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 drive_en", pad_drive_en, 8'h00);
        check("R1 pullup", pad_pullup_en, 8'h00);
        check("R1 irq", irq, 0);
        rd(3'd1, r); check("R1 dir reg", r, 8'h00);
        rd(3'd2, r); check("R1 opt reg", r, 8'h00);
        rd(3'd4, r); check("R1 sens reg", r, 8'h00);

        // R2..R5 directed: bits 0-1 float in, 2-3 pull-up in, 4-5 open-drain, 6-7 push-pull
        wr(3'd1, 8'hF0); wr(3'd2, 8'hCC); wr(3'd0, 8'hA5);
        float_lvl = 8'h01;
        check("R2 float no drive", pad_drive_en & 8'h03, 8'h00);
        check("R2 float no pull", pad_pullup_en & 8'h03, 8'h00);
        check("R5 pullup on", pad_pullup_en & 8'h0C, 8'h0C);
        check("R3 open-drain enables", pad_drive_en & 8'h30, 8'h10);
        check("R3 open-drain low", pad_drive_val & 8'h10, 8'h00);
        check("R4 push-pull enables", pad_drive_en & 8'hC0, 8'hC0);
        check("R4 push-pull value", pad_drive_val & 8'hC0, 8'h80);
        settle();
        rd(3'd0, r); check("R7 data read pad", r, exp_pad());
        rd(3'd1, r); check("R7 dir readback", r, 8'hF0);
        rd(3'd2, r); check("R7 opt readback", r, 8'hCC);
        rd(3'd5, r); check("R7 unused addr", r, 8'h00);

        // R6 alternate override on an input and an open-drain bit
        alt_en = 8'h11; alt_out = 8'h11;
        #1;
        check("R6 alt enable", pad_drive_en & 8'h11, 8'h11);
        check("R6 alt value", pad_drive_val & 8'h11, 8'h11);
        alt_en = 8'h00; alt_out = 8'h00;

        // R7 synchronizer latency on a floating input
        wr(3'd1, 8'h00); wr(3'd2, 8'h00);
        ext_en = 8'h00; float_lvl = 8'h00; settle();
        float_lvl = 8'h02;
        @(negedge clk); rd(3'd0, r); check("R7 not after one edge", r, 8'h00);
        @(negedge clk); rd(3'd0, r); check("R7 visible after two edges", r, 8'h02);

        // random configurations
        for (int it = 0; it < 40; it++) begin
            logic [7:0] en_m;
            alt_en = 8'($urandom) & 8'($urandom) & 8'($urandom);
            alt_out = 8'($urandom);
            ext_en = 8'($urandom); ext_val = 8'($urandom); float_lvl = 8'($urandom);
            wr(3'd1, 8'($urandom)); wr(3'd2, 8'($urandom)); wr(3'd0, 8'($urandom));
            settle();
            en_m = exp_en();
            check("R2-R6 random drive_en", pad_drive_en, en_m);
            check("R3/R4/R6 random value", pad_drive_val & en_m, exp_val() & en_m);
            check("R5 random pullup", pad_pullup_en, exp_pull());
            rd(3'd0, r); check("R7 random pad read", r, exp_pad());
        end

        // interrupt setup: all pins pulled-up inputs, idle high
        alt_en = 8'h00; ext_en = 8'h00; ext_val = 8'h00; float_lvl = 8'h00;
        wr(3'd1, 8'h00); wr(3'd2, 8'hFF); wr(3'd4, 8'h01);
        settle(); wr(3'd3, 8'hFF); settle();
        check("R9 idle no request", irq_req, 8'h00);

        // R9 falling latched
        ext_en = 8'h01; settle();
        check("R9 falling sets", irq_req, 8'h01);
        check("R11 irq is OR", irq, 1);
        ext_en = 8'h00; settle();
        check("R9 falling held after release", irq_req, 8'h01);
        wr(3'd3, 8'hFE); settle();
        check("R9 zero bits do not clear", irq_req, 8'h01);
        rd(3'd3, r); check("R11 request read", r, 8'h01);
        wr(3'd3, 8'h01); #1;
        check("R9 w1c clears", irq_req, 8'h00);
        ext_en = 8'h28; settle();
        check("R9 two falling bits", irq_req, 8'h28);
        wr(3'd3, 8'hFF); settle();
        ext_en = 8'h00; settle();
        check("R9 rising ignored in falling mode", irq_req, 8'h00);

        // R9 rising
        wr(3'd4, 8'h02); settle();
        ext_en = 8'h04; settle();
        check("R9 falling ignored in rising mode", irq_req, 8'h00);
        ext_en = 8'h00; settle();
        check("R9 rising sets", irq_req, 8'h04);
        wr(3'd3, 8'hFF); settle();

        // R9 both edges
        wr(3'd4, 8'h03); settle();
        ext_en = 8'h40; settle();
        check("R9 both: falling sets", irq_req, 8'h40);
        wr(3'd3, 8'h40); settle();
        ext_en = 8'h00; settle();
        check("R9 both: rising sets", irq_req, 8'h40);
        wr(3'd3, 8'hFF); settle();

        // R10 level, not latched
        wr(3'd4, 8'h00); settle();
        ext_en = 8'h80; settle();
        check("R10 low level requests", irq_req, 8'h80);
        ext_en = 8'h00; settle();
        check("R10 request drops when high", irq_req, 8'h00);
        rd(3'd3, r); check("R10 read after release", r, 8'h00);

        // R8 disabled bits: outputs, no-option inputs, alternate-function bits
        wr(3'd4, 8'h03); wr(3'd3, 8'hFF);
        wr(3'd2, 8'hF0); wr(3'd1, 8'hC0); wr(3'd0, 8'hFF);
        float_lvl = 8'h0F; settle(); wr(3'd3, 8'hFF); settle();
        ext_en = 8'h03; settle(); ext_en = 8'h00; settle();
        check("R8 no request without option", irq_req, 8'h00);
        wr(3'd0, 8'h00); settle(); wr(3'd0, 8'hFF); settle();
        check("R8 no request on outputs", irq_req, 8'h00);
        alt_en = 8'h10; alt_out = 8'h10; settle();
        alt_out = 8'h00; settle(); alt_out = 8'h10; settle();
        check("R8 no request under alternate function", irq_req, 8'h00);
        check("R6 alternate pullup off", pad_pullup_en & 8'h10, 8'h00);
        check("R11 irq idle", irq, 0);

        finish_run();
    end

endmodule